// File: doc/BRIEF.md
# Framed Configuration Stream CRC Checker

This block sits on the path that loads a configuration image and vets it one frame at a time. The image arrives as 32-bit words on a valid/ready stream. Each frame is a fixed number of payload words followed by one word holding that frame's expected CRC-32. The block recomputes the CRC over each payload and compares it with the carried word.

The first bad frame, or a frame-start marker in the wrong place, stops the load. From then on the block refuses all input until a synchronous reset. When the CRC word of the frame flagged as final matches, the block raises a one-cycle completion pulse. On that same cycle it stores a 32-bit reference CRC, computed over the payload of every frame in the load, for a later continuous integrity checker to use.

Back-pressure rules: a word transfers only on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high while a load is in progress. It drops for good once the load has failed or finished. The source may hold `in_valid` low for any number of cycles. Data, start and final markers are ignored while no transfer takes place.

Top module: `cfg_frame_crc_chk`

## Requirements
- R1: While `rst_n` is low and after it is released, `load_err` is 0, `load_done` is 0, `ref_crc` is 0 and `in_ready` is 1.
- R2: The CRC is the reflected CRC-32 with polynomial 0xEDB88320, initial value 0xFFFFFFFF and a final inversion. Each word is fed least significant bit first. A frame whose CRC word (word index FRAME_WORDS, after payload indices 0 to FRAME_WORDS-1) equals this value passes without raising `load_err`.
- R3: If an accepted CRC word differs from the computed value, `load_err` is 1 from the cycle after that transfer and stays 1 until reset. `load_done` is not asserted for that load.
- R4: After `load_err` rises, `in_ready` is 0. Further words are not accepted, `load_done` stays 0 and `ref_crc` keeps its value.
- R5: The per-frame CRC restarts at 0xFFFFFFFF on the first payload word of every frame. Two frames with identical payload therefore carry identical CRC words, and both pass.
- R6: When the CRC word carrying `in_final`=1 matches, `load_done` is 1 for exactly the one cycle after that transfer.
- R7: `ref_crc` changes only in the cycle `load_done` is 1. It then holds the R2 CRC (same initial value and inversion) computed over the payload words of all frames of the load, in arrival order.
- R8: After a completed load, `in_ready` is 0. Further input changes neither `load_err`, `load_done` nor `ref_crc`.
- R9: `in_sof` must be 1 on payload word 0 of a frame and 0 on every other word. Any violation on an accepted word sets `load_err` from the next cycle.
- R10: Cycles with `in_valid` low consume nothing, whatever `in_data` holds, so idle gaps inside a frame do not change the outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source has a word |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 32 | Payload or CRC word |
| in_sof | input | 1 | Marks payload word 0 of a frame |
| in_final | input | 1 | On a CRC word: this frame is the last of the load |
| load_err | output | 1 | Sticky mismatch or framing error |
| load_done | output | 1 | One-cycle pulse after the final frame passes |
| ref_crc | output | 32 | Stored reference CRC of the whole load |

## Verification
The bench builds the block with FRAME_WORDS set to 4 rather than 16. This keeps single-frame and four-frame loads short, so the run covers more of them. With the smaller frame, a corrupt CRC can be placed in the first, a middle or the final frame. Loads with idle gaps inside frames and loads that continue past completion or failure also stay within reach. The framing check and the per-frame restart do not depend on the frame length, so a frame of 4 payload words exercises them just as a frame of 16 would.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    LD_RUN  = 2'd0,
    LD_FAIL = 2'd1,
    LD_OK   = 2'd2
  } ld_state_e;
endpackage

// File: rtl/cfc_crc_step.sv
// One word of reflected CRC folded in a single cycle: an unrolled chain of
// shift/conditional-xor stages, one per data bit.
module cfc_crc_step #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = 32'hEDB88320
) (
  input  logic [W-1:0] crc_in,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] crc_out
);
  logic [W-1:0] stg [0:W];

  assign stg[0] = crc_in ^ data_in;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign stg[b+1] = stg[b][0] ? ((stg[b] >> 1) ^ POLY) : (stg[b] >> 1);
  end

  assign crc_out = stg[W];
endmodule

// File: rtl/cfc_crc_accum.sv
// CRC accumulator register; restart selects the initial value as the base
// for the word being folded in.
module cfc_crc_accum
  import cfc_pkg::*;
#(
  parameter int unsigned W = CRC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] data,
  output logic [W-1:0] acc
);
  logic [W-1:0] base;
  logic [W-1:0] nxt;

  assign base = restart ? W'(CRC_INIT) : acc;

  cfc_crc_step #(.W(W), .POLY(W'(CRC_POLY))) u_step (
    .crc_in (base),
    .data_in(data),
    .crc_out(nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= W'(CRC_INIT);
    else if (en) acc <= nxt;
  end
endmodule

// File: rtl/cfc_frame_seq.sv
// Tracks the position inside a frame: payload slots 0..FRAME_WORDS-1, then
// the CRC slot.
module cfc_frame_seq #(
  parameter int unsigned FRAME_WORDS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  output logic at_first,
  output logic at_crc
);
  localparam int unsigned CW = $clog2(FRAME_WORDS + 1);
  localparam logic [CW-1:0] CRC_SLOT = CW'(FRAME_WORDS);

  logic [CW-1:0] pos;

  assign at_first = (pos == '0);
  assign at_crc   = (pos == CRC_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n)    pos <= '0;
    else if (beat) pos <= at_crc ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/cfg_frame_crc_chk.sv
module cfg_frame_crc_chk
  import cfc_pkg::*;
#(
  parameter int unsigned FRAME_WORDS = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_final,
  output logic          load_err,
  output logic          load_done,
  output logic [DW-1:0] ref_crc
);
  localparam int unsigned N_ACC = 2;   // 0: per-frame, 1: whole load
  localparam int unsigned ACC_FRM = 0;
  localparam int unsigned ACC_IMG = 1;

  ld_state_e state;
  logic beat, pay_beat, crc_beat;
  logic at_first, at_crc;
  logic sof_bad, crc_bad, fail_now;
  logic [DW-1:0] acc [N_ACC];

  assign in_ready = (state == LD_RUN);
  assign beat     = in_valid & in_ready;
  assign pay_beat = beat & ~at_crc;
  assign crc_beat = beat & at_crc;

  cfc_frame_seq #(.FRAME_WORDS(FRAME_WORDS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (beat),
    .at_first(at_first),
    .at_crc  (at_crc)
  );

  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    logic rs;
    if (g == ACC_FRM) begin : g_frm
      assign rs = at_first;
    end else begin : g_img
      assign rs = 1'b0;
    end
    cfc_crc_accum #(.W(DW)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (pay_beat),
      .restart(rs),
      .data   (in_data),
      .acc    (acc[g])
    );
  end

  assign sof_bad  = beat & (in_sof != at_first);
  assign crc_bad  = crc_beat & (in_data != ~acc[ACC_FRM]);
  assign fail_now = sof_bad | crc_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= LD_RUN;
      load_done <= 1'b0;
      ref_crc   <= '0;
    end else begin
      load_done <= 1'b0;
      if (beat) begin
        if (fail_now) begin
          state <= LD_FAIL;
        end else if (crc_beat && in_final) begin
          state     <= LD_OK;
          load_done <= 1'b1;
          ref_crc   <= ~acc[ACC_IMG];
        end
      end
    end
  end

  assign load_err = (state == LD_FAIL);
endmodule

// File: rtl/cfg_frame_crc_chk_sva.sv
module cfg_frame_crc_chk_sva #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic          in_sof,
  input logic          in_final,
  input logic          load_err,
  input logic          load_done,
  input logic [DW-1:0] ref_crc
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |=> load_err); // R3
  AST_NO_READY_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> !in_ready); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !load_done); // R6
  AST_DONE_EXCLUDES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_done && load_err)); // R3
  AST_REF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> $stable(ref_crc)); // R7
  AST_NO_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> !in_ready); // R8
endmodule

bind cfg_frame_crc_chk cfg_frame_crc_chk_sva #(.DW(DW)) u_sva (.*);

// File: tb/cfg_frame_crc_chk_tb_top.sv
module cfg_frame_crc_chk_tb_top;
  localparam int FW = 4;

  typedef struct packed {
    logic [7:0] nfr;
    logic [7:0] bad;   // 15 = no corrupt frame
    logic [7:0] seed;
    logic [7:0] gap;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 8'd15, 8'd1, 8'd0},
    '{8'd3, 8'd15, 8'd2, 8'd0},
    '{8'd3, 8'd1,  8'd3, 8'd0},
    '{8'd2, 8'd0,  8'd4, 8'd1},
    '{8'd4, 8'd3,  8'd5, 8'd0},
    '{8'd2, 8'd15, 8'd6, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_data = '0;
  logic in_sof = 1'b0;
  logic in_final = 1'b0;
  logic load_err, load_done;
  logic [31:0] ref_crc;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] img;
  logic [31:0] pl [FW];

  always #4 clk = ~clk;

  cfg_frame_crc_chk #(.FRAME_WORDS(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_final(in_final),
    .load_err(load_err), .load_done(load_done), .ref_crc(ref_crc)
  );

  function automatic logic [31:0] crc_fold(logic [31:0] c, logic [31:0] d);
    c = c ^ d;
    for (int i = 0; i < 32; i++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  function automatic logic [31:0] pat(int seed, int f, int w);
    return {seed[7:0], f[7:0], w[7:0], 8'hA5} ^ (32'(w + 1) * 32'h9E3779B9);
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] d, bit sof, bit fin);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sof = sof; in_final = fin;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_data = 32'hDEADBEEF; in_sof = 1'b1; in_final = 1'b1;
  endtask

  // Sends the frame held in pl; returns after the negedge following the CRC word.
  task automatic send_frame(bit fin, bit corrupt, bit gap, bit bad_sof);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int w = 0; w < FW; w++) begin
      drive(pl[w], (w == 0) ^ bad_sof, 1'b0);
      c = crc_fold(c, pl[w]);
      if (gap) begin idle(); idle(); end
    end
    drive(~c ^ {31'd0, corrupt}, 1'b0, fin);
    idle();
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(load_err == 1'b0,  "R1 err in reset",  {31'd0, load_err}, 32'd0);
    check(load_done == 1'b0, "R1 done in reset", {31'd0, load_done}, 32'd0);
    check(ref_crc == 32'd0,  "R1 ref in reset",  ref_crc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1,  "R1 ready after reset", {31'd0, in_ready}, 32'd1);
    img = 32'hFFFFFFFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R6 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    // Table-driven loads
    for (int v = 0; v < NV; v++) begin
      bit failed;
      failed = 1'b0;
      do_reset();
      for (int f = 0; f < int'(VECS[v].nfr); f++) begin
        for (int w = 0; w < FW; w++) pl[w] = pat(int'(VECS[v].seed), f, w);
        if (!failed) for (int w = 0; w < FW; w++) img = crc_fold(img, pl[w]);
        send_frame(f == int'(VECS[v].nfr) - 1, f == int'(VECS[v].bad),
                   VECS[v].gap[0], 1'b0);
        if (f == int'(VECS[v].bad)) begin
          check(load_err == 1'b1,  "R3 mismatch flagged", {31'd0, load_err}, 32'd1);
          check(load_done == 1'b0, "R3 no done on bad",   {31'd0, load_done}, 32'd0);
          failed = 1'b1;
        end else if (failed) begin
          check(in_ready == 1'b0 && load_err == 1'b1, "R4 ignored after err",
                {30'd0, in_ready, load_err}, 32'd1);
          check(load_done == 1'b0 && ref_crc == 32'd0, "R4 no done/ref after err",
                ref_crc, 32'd0);
        end else begin
          check(load_err == 1'b0, "R2 good frame passes", {31'd0, load_err}, 32'd0);
          if (VECS[v].gap[0])
            check(load_err == 1'b0, "R10 gaps harmless", {31'd0, load_err}, 32'd0);
        end
      end
      if (!failed) begin
        check(load_done == 1'b1, "R6 done pulse", {31'd0, load_done}, 32'd1);
        check(ref_crc == ~img,   "R7 reference CRC", ref_crc, ~img);
        idle();
        check(load_done == 1'b0, "R6 done one cycle", {31'd0, load_done}, 32'd0);
        check(in_ready == 1'b0,  "R8 ready low after done", {31'd0, in_ready}, 32'd0);
      end
    end

    // R9: missing start marker on payload word 0
    do_reset();
    drive(32'h12345678, 1'b0, 1'b0);
    idle();
    check(load_err == 1'b1, "R9 missing sof", {31'd0, load_err}, 32'd1);

    // R9: start marker on payload word 1
    do_reset();
    drive(32'h11111111, 1'b1, 1'b0);
    drive(32'h22222222, 1'b1, 1'b0);
    idle();
    check(load_err == 1'b1, "R9 stray sof", {31'd0, load_err}, 32'd1);

    // R5: identical frames, each carrying the same CRC word
    do_reset();
    for (int w = 0; w < FW; w++) pl[w] = pat(9, 0, w);
    for (int k = 0; k < 2; k++) for (int w = 0; w < FW; w++) img = crc_fold(img, pl[w]);
    send_frame(1'b0, 1'b0, 1'b0, 1'b0);
    check(load_err == 1'b0, "R5 first copy passes", {31'd0, load_err}, 32'd0);
    send_frame(1'b1, 1'b0, 1'b0, 1'b0);
    check(load_err == 1'b0 && load_done == 1'b1, "R5 second copy passes",
          {30'd0, load_err, load_done}, 32'd1);
    check(ref_crc == ~img, "R7 reference over two frames", ref_crc, ~img);
    held = ref_crc;

    // R8: input after a completed load is ignored
    for (int w = 0; w < FW; w++) pl[w] = pat(10, 0, w);
    send_frame(1'b1, 1'b1, 1'b0, 1'b1);
    check(load_err == 1'b0 && load_done == 1'b0, "R8 no err/done after finish",
          {30'd0, load_err, load_done}, 32'd0);
    check(ref_crc == held, "R8 ref unchanged after finish", ref_crc, held);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule